// File: doc/BRIEF.md
# Iterative Floating-Point Square Root Unit

This block computes the square root of a number held in a compact 24-bit floating-point word. The word has three fields. Bits [23:16] hold an exponent with a bias of 127. Bit 15 is the sign. Bits [14:0] are the fraction below an implicit leading one. A one-cycle `start` captures the operand. The unit then produces one root bit per clock cycle with a non-restoring square-root recurrence. Each step brings two radicand bits into a signed partial remainder. When the remainder is non-negative, the step subtracts the current root with 01 appended. When the remainder is negative, it adds the current root with 11 appended. Each new root bit is the inverse of the remainder sign.

The sign is ignored, so the root is taken of the magnitude. The result exponent is the biased exponent minus one, shifted right by one, plus 64. This halves the unbiased exponent and rounds toward minus infinity. An odd biased exponent shifts the mantissa left by one before iterating. That shift fixes the first root bit to one, so one step fewer is needed. After the mantissa bits are consumed, zero pairs are fed in, and iteration continues until a 16-bit root with its top bit set is formed. The result is truncated, not rounded. An exponent of zero means the value is zero: the operand is returned unchanged at once. An exponent of 255 gets no special treatment.

Top module: `fsqrt_unit`

## Requirements
- R1: When `start` is sampled with `busy` low and `operand[23:16]` equal to 0, `done` is high in the next cycle. `result` then equals the operand bit for bit, and `busy` stays low.
- R2: The sign bit `operand[15]` has no effect on a nonzero result. For any nonzero result, `result[15]` is 0.
- R3: For an operand exponent E in 1..255, `result[23:16]` equals ((E-1)>>1)+64, taken to 8 bits. E=1 gives 64, E=127 gives 127, and E=255 gives 191.
- R4: Let M be the 16-bit value `{1, operand[14:0]}`. `result[14:0]` holds the low 15 bits of floor(sqrt(M·2^16)) when E is even, and of floor(sqrt(M·2^15)) when E is odd. That 16-bit root always has bit 15 set.
- R5: For a nonzero operand, `done` rises on the 16th clock edge after the edge that samples `start` when E is even, and on the 15th edge when E is odd.
- R6: `busy` is high from the cycle after a nonzero start until `done` rises. `done` lasts one cycle and is never high together with `busy`.
- R7: `result` changes only on the edge that raises `done`, and holds between done pulses.
- R8: A `start` sampled while `busy` is high has no effect. The running operation keeps its latency and result, and no extra `done` follows.
- R9: After reset, `busy` and `done` are low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to capture `operand` |
| operand | input | 24 | Input word: exponent [23:16], sign [15], fraction [14:0] |
| result | output | 24 | Root in the same format, held until the next done |
| busy | output | 1 | High while root bits are being produced |
| done | output | 1 | One-cycle pulse when `result` is updated |

## Verification
The embedded assertions check the following on every cycle:
- the handshake: busy and done are exclusive, done follows the last step, and a running count is not reloaded by a late start;
- that the result holds between done pulses;
- that the final root has its top bit set;
- that the cleared sign and exponent window of nonzero results hold;
- that zero passes through unchanged.

The arithmetic value of the root can only be shown by the bench scenarios. These compare each result with an integer square root computed by a different, restoring method. They cover the exponent extremes 1, 254 and 255, negative inputs, and all-ones and sparse fractions. The bench also covers the odd/even latency difference and a start injected in the middle of a run.

// File: rtl/fsqrt_pkg.sv
// fsqrt_pkg: shared sizes and the iteration state type for the square-root unit.
// Assumes a word of one exponent field and one mantissa field whose top bit is the sign.
package fsqrt_pkg;
    parameter int EXP_W  = 8;                  // biased exponent width
    parameter int MAN_W  = 16;                 // mantissa field width (sign at top)
    localparam int WORD_W = EXP_W + MAN_W;     // full word width
    localparam int RAD_W  = 2 * MAN_W;         // radicand shift register width
    localparam int REM_W  = MAN_W + 5;         // signed partial remainder width
    localparam int CNT_W  = $clog2(MAN_W + 1); // step counter width
    localparam int HALF_BIAS = 2 ** (EXP_W - 2); // bias correction after halving

    // State carried from one root step to the next
    typedef struct packed {
        logic [REM_W-1:0] rem;   // two's-complement partial remainder
        logic [MAN_W-1:0] root;  // root bits found so far
        logic [RAD_W-1:0] rad;   // radicand bits not yet consumed, MSB first
    } sq_state_t;
endpackage

// File: rtl/fsqrt_prep.sv
// fsqrt_prep: unpacks an operand into the starting state of the root recurrence.
// Detects zero, halves the exponent, and applies the odd-exponent pre-shift
// (first root bit preset, one step fewer). Purely combinational.
module fsqrt_prep
    import fsqrt_pkg::*;
(
    input  logic [WORD_W-1:0] operand,
    output logic              is_zero,
    output logic [EXP_W-1:0]  half_exp,
    output sq_state_t         init_st,
    output logic [CNT_W-1:0]  init_cnt
);
    logic [EXP_W-1:0] bexp;
    logic [MAN_W-1:0] mant;
    logic             odd;

    // Split fields; the sign position becomes the explicit leading one
    always_comb begin
        bexp = operand[WORD_W-1 -: EXP_W];
        mant = {1'b1, operand[MAN_W-2:0]};
        odd  = bexp[0];
    end

    // Zero test and exponent halving rounded toward minus infinity
    always_comb begin
        is_zero  = (bexp == '0);
        half_exp = ((bexp - EXP_W'(1)) >> 1) + EXP_W'(HALF_BIAS);
    end

    // Starting state: odd exponents consume the leading pair 01 up front
    always_comb begin
        init_st.rem = '0;
        if (odd) begin
            init_st.root = MAN_W'(1);
            init_st.rad  = {mant[MAN_W-2:0], {(MAN_W+1){1'b0}}};
            init_cnt     = CNT_W'(MAN_W - 1);
        end else begin
            init_st.root = '0;
            init_st.rad  = {mant, {MAN_W{1'b0}}};
            init_cnt     = CNT_W'(MAN_W);
        end
    end
endmodule

// File: rtl/fsqrt_step.sv
// fsqrt_step: one non-restoring square-root step (two radicand bits in,
// one root bit out). Assumes the remainder is wide enough never to overflow.
// Purely combinational.
module fsqrt_step
    import fsqrt_pkg::*;
(
    input  sq_state_t cur,
    output sq_state_t nxt
);
    logic [REM_W-1:0] shifted;
    logic [REM_W-1:0] trial;
    logic             neg;

    // Bring in the next two radicand bits and form the trial term
    always_comb begin
        neg     = cur.rem[REM_W-1];
        shifted = {cur.rem[REM_W-3:0], cur.rad[RAD_W-1 -: 2]};
        trial   = {{(REM_W-MAN_W-2){1'b0}}, cur.root, neg, 1'b1};
    end

    // Subtract after a non-negative remainder, add after a negative one
    always_comb begin
        nxt.rem  = neg ? (shifted + trial) : (shifted - trial);
        nxt.root = {cur.root[MAN_W-2:0], ~nxt.rem[REM_W-1]};
        nxt.rad  = {cur.rad[RAD_W-3:0], 2'b00};
    end
endmodule

// File: rtl/fsqrt_unit.sv
// fsqrt_unit: sequential square root of a 24-bit sign-in-mantissa float.
// One root bit per cycle; zero returns at once; the sign is ignored and the
// root truncated. A start while busy is ignored. Result held until next done.
module fsqrt_unit
    import fsqrt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] operand,
    output logic [WORD_W-1:0] result,
    output logic              busy,
    output logic              done
);
    logic              p_zero;
    logic [EXP_W-1:0]  p_exp;
    sq_state_t         p_st;
    logic [CNT_W-1:0]  p_cnt;
    sq_state_t         st_q;
    sq_state_t         st_n;
    logic [CNT_W-1:0]  cnt_q;
    logic [EXP_W-1:0]  rexp_q;
    logic [WORD_W-1:0] res_q;
    logic              busy_q;
    logic              done_q;

    fsqrt_prep u_prep (
        .operand  (operand),
        .is_zero  (p_zero),
        .half_exp (p_exp),
        .init_st  (p_st),
        .init_cnt (p_cnt)
    );

    fsqrt_step u_step (
        .cur (st_q),
        .nxt (st_n)
    );

    // Sequencer: accept start when idle, step while busy, publish on last step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= '0;
            cnt_q  <= '0;
            rexp_q <= '0;
            res_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q && start) begin
                if (p_zero) begin
                    res_q  <= operand;
                    done_q <= 1'b1;
                end else begin
                    busy_q <= 1'b1;
                    st_q   <= p_st;
                    cnt_q  <= p_cnt;
                    rexp_q <= p_exp;
                end
            end else if (busy_q) begin
                st_q  <= st_n;
                cnt_q <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    res_q  <= {rexp_q, 1'b0, st_n.root[MAN_W-2:0]};
                end
            end
        end
    end

    // Drive outputs from registers
    always_comb begin
        result = res_q;
        busy   = busy_q;
        done   = done_q;
    end

    AST_ZERO_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && operand[WORD_W-1 -: EXP_W] == '0) |=> (done && !busy && result == $past(operand))); // R1
    AST_SIGN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result[WORD_W-1 -: EXP_W] != '0) |-> !result[MAN_W-1]); // R2
    AST_EXP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result[WORD_W-1 -: EXP_W] != '0) |-> (result[WORD_W-1 -: EXP_W] >= EXP_W'(HALF_BIAS)
            && result[WORD_W-1 -: EXP_W] <= EXP_W'(3 * HALF_BIAS - 1))); // R3
    AST_ROOT_MSB_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q == CNT_W'(1)) |-> st_n.root[MAN_W-1]); // R4
    AST_LAST_STEP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q == CNT_W'(1)) |=> (done && !busy)); // R5
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done); // R6
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result)); // R7
    AST_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q != CNT_W'(1)) |=> (busy && cnt_q == CNT_W'($past(cnt_q) - CNT_W'(1)))); // R8
endmodule

// File: tb/tb_fsqrt_unit.sv
`timescale 1ns/1ps
// tb_fsqrt_unit: scoreboard bench. The driver queues expected words from a
// restoring integer square-root model; the monitor pops and compares on done.
module tb_fsqrt_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] operand = '0;
    logic [23:0] result;
    logic        busy;
    logic        done;

    int checks = 0;
    int fails  = 0;
    logic [23:0] exp_q[$];
    logic [23:0] last_res = '0;
    logic        finished = 1'b0;

    always #2.5 clk = ~clk;

    fsqrt_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .operand(operand),
        .result(result), .busy(busy), .done(done)
    );

    function automatic logic [15:0] isqrt(longint v);
        longint r = 0;
        for (int b = 15; b >= 0; b--) begin
            longint t = r | (longint'(1) << b);
            if (t * t <= v) r = t;
        end
        return r[15:0];
    endfunction

    function automatic logic [23:0] model(logic [23:0] op);
        logic [7:0]  e = op[23:16];
        longint      m = longint'({1'b1, op[14:0]});
        logic [15:0] r;
        logic [7:0]  er;
        if (e == 8'd0) return op;
        r  = e[0] ? isqrt(m << 15) : isqrt(m << 16);
        er = 8'((e - 8'd1) >> 1) + 8'd64;
        return {er, 1'b0, r[14:0]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    // Monitor: compare each done against the scoreboard; check hold otherwise
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected done", 32'(result), 32'h0);
                end else begin
                    logic [23:0] e;
                    e = exp_q.pop_front();
                    if (e[23:16] == 8'd0) begin
                        check(result == e, "R1 zero passthrough", 32'(result), 32'(e));
                    end else begin
                        check(result[23:16] == e[23:16], "R3 exponent", 32'(result[23:16]), 32'(e[23:16]));
                        check(result[15] == 1'b0, "R2 sign cleared", 32'(result[15]), 32'h0);
                        check(result[14:0] == e[14:0], "R4 mantissa", 32'(result[14:0]), 32'(e[14:0]));
                    end
                end
                last_res = result;
            end else begin
                check(result == last_res, "R7 result hold", 32'(result), 32'(last_res));
            end
        end
    end

    // Driver: launch one operand, optionally inject a start mid-run, measure latency
    task automatic run_op(input logic [23:0] op, input int inj);
        int k;
        int lat;
        lat = (op[23:16] == 8'd0) ? 0 : (op[16] ? 15 : 16);
        @(negedge clk);
        operand = op;
        start = 1'b1;
        exp_q.push_back(model(op));
        @(negedge clk);
        start = 1'b0;
        k = 0;
        if (lat == 0) check(busy == 1'b0, "R1 busy stays low", 32'(busy), 32'h0);
        while (!done && k < 40) begin
            check(busy == 1'b1, "R6 busy while running", 32'(busy), 32'h1);
            if (k == inj) begin
                operand = ~op;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            k++;
        end
        start = 1'b0;
        check(k == lat, "R5 latency", 32'(k), 32'(lat));
        check(busy == 1'b0, "R6 busy low at done", 32'(busy), 32'h0);
        @(negedge clk);
        check(done == 1'b0, "R6 done one cycle", 32'(done), 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        logic [23:0] lfsr;
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R9 reset busy", 32'(busy), 32'h0);
        check(done == 1'b0, "R9 reset done", 32'(done), 32'h0);
        check(result == 24'h0, "R9 reset result", 32'(result), 32'h0);
        rst_n = 1'b1;
        run_op(24'h000000, -1);  // R1 plain zero
        run_op(24'h008123, -1);  // R1 zero exponent with junk mantissa
        run_op(24'h7F0000, -1);  // 1.0
        run_op(24'h800000, -1);  // 2.0, even exponent
        run_op(24'h810000, -1);  // 4.0
        run_op(24'h818000, -1);  // R2 -4.0 gives +2.0
        run_op(24'h817FFF, -1);  // R2 pairs with the next
        run_op(24'h81FFFF, -1);
        run_op(24'h017FFF, -1);  // R3 smallest exponent
        run_op(24'hFFFFFF, -1);  // R3 largest exponent
        run_op(24'hFE0001, -1);
        run_op(24'h9A5A5A, -1);
        run_op(24'h832468, 5);   // R8 start injected while busy (odd)
        run_op(24'h40A5A5, 3);   // R8 start injected while busy (even)
        lfsr = 24'hACE135;
        for (int i = 0; i < 40; i++) begin
            lfsr = {lfsr[22:0], lfsr[23] ^ lfsr[22] ^ lfsr[21] ^ lfsr[16]};
            run_op(lfsr, -1);
        end
        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R8 no pending results", 32'(exp_q.size()), 32'h0);
        check(done == 1'b0, "R8 no extra done", 32'(done), 32'h0);
        summary();
    end
endmodule